// File: doc/BRIEF.md
# Cache-Line Address Monitor

This unit keeps track of one memory line on behalf of a core that runs a monitor/wait pair of instructions for low-power idling. The monitor request loads a target virtual address and arms the unit. The wait request then supplies the translated physical address. The unit aligns it to the line, stores it, and answers "sleep", or it answers "do not sleep" when a wakeup has already been collected. The answer comes one cycle after the request.

Coherence snoops and invalidations present physical line addresses. A snoop that equals the stored line, while the unit is armed and waiting, returns the core to work with a one-cycle wakeup pulse. The same snoop arriving before the core has started waiting is kept as a pending wakeup, so the next wait returns at once.

The unit also reports how many bytes of the monitored access fall inside the first line. An access that would cross into the next line is cut short, so that only the first line is watched.

Top module: `line_monitor`

## Requirements
- R1: After reset the armed, waiting and pending flags are clear, and wakeup_o, rsp_valid_o and rsp_sleep_o are 0.
- R2: A monitor request sets armed and stores the given virtual address. It sets the stored line to zero, clears any pending wakeup and leaves the waiting flag as it was. All of these are visible on the next cycle.
- R3: A wait request with no pending wakeup stores its physical address with the low log2(LINE_BYTES) bits cleared and sets waiting. On the next cycle rsp_valid_o=1 and rsp_sleep_o=1.
- R4: A wait request with a pending wakeup clears the pending flag and leaves the waiting flag and the stored line unchanged. On the next cycle rsp_valid_o=1 and rsp_sleep_o=0.
- R5: A snoop is acted on only when it equals the stored line, and for a wakeup it needs armed and waiting both set. The equality covers all address bits. On a hit, waiting clears and wakeup_o is 1 for exactly the next cycle. Any other snoop changes nothing.
- R6: A snoop equal to the stored line while armed and not waiting sets the pending flag and gives no wakeup.
- R7: A monitor request takes priority. A snoop in the same cycle is ignored. A wait request in the same cycle is dropped and gets no response.
- R8: mon_span_o equals LINE_BYTES minus (stored virtual address modulo LINE_BYTES). An aligned address gives the full LINE_BYTES.
- R9: When a wait and a snoop arrive in the same cycle, the snoop is judged on the state from before the wait. The wait's flag and line updates are applied after it, and the snoop then sets no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_req_i | input | 1 | Monitor (arm) request |
| arm_vaddr_i | input | ADDR_W | Virtual address to monitor |
| wait_req_i | input | 1 | Wait request |
| wait_paddr_i | input | ADDR_W | Translated physical address for the wait |
| snoop_valid_i | input | 1 | Snoop / invalidation address valid |
| snoop_paddr_i | input | ADDR_W | Snoop physical line address |
| armed_o | output | 1 | Monitor armed |
| waiting_o | output | 1 | Core waiting on the line |
| mon_vaddr_o | output | ADDR_W | Stored virtual address |
| mon_line_o | output | ADDR_W | Stored line-aligned physical address |
| mon_span_o | output | log2(LINE_BYTES)+1 | Bytes monitored within the first line |
| rsp_valid_o | output | 1 | Wait response valid (one cycle after request) |
| rsp_sleep_o | output | 1 | 1 = sleep, 0 = return at once |
| wakeup_o | output | 1 | One-cycle wakeup pulse |

## Verification
Every in-line offset of the virtual address is swept across two lines to confirm the span arithmetic. Every physical address in a 256-byte window is sent through a wait to check the line masking.

A snoop address sweep around a target line shows that a hit needs exact equality of the whole address: neighbouring lines and unaligned addresses must not wake the core.

Directed orderings cover the remaining cases:
- a snoop before the wait, which gives a pending wakeup and then an immediate return;
- a monitor request colliding with a snoop or with a wait;
- a wait and a snoop in the same cycle.

// File: rtl/lmon_pkg.sv
package lmon_pkg;

    typedef enum logic [1:0] {
        SNP_NONE = 2'd0,
        SNP_WAKE = 2'd1,
        SNP_PEND = 2'd2
    } snp_kind_e;

endpackage

// File: rtl/lmon_line_align.sv
module lmon_line_align #(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] line_o
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    generate
        if (OFS_W == 0) begin : g_byte_line
            assign line_o = addr_i;
        end else begin : g_masked
            assign line_o = {addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/lmon_span_calc.sv
module lmon_span_calc #(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64
) (
    input  logic [ADDR_W-1:0]                 vaddr_i,
    output logic [$clog2(LINE_BYTES):0]       span_o
);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int SPAN_W = OFS_W + 1;
    localparam logic [SPAN_W-1:0] FULL = SPAN_W'(LINE_BYTES);

    // Bytes from the start address up to the start of the following line.
    generate
        if (OFS_W == 0) begin : g_unit
            assign span_o = FULL;
        end else begin : g_offset
            logic [SPAN_W-1:0] ofs;
            assign ofs    = {1'b0, vaddr_i[OFS_W-1:0]};
            assign span_o = FULL - ofs;
        end
    endgenerate
endmodule

// File: rtl/lmon_snoop_cmp.sv
module lmon_snoop_cmp
    import lmon_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] line_i,
    input  logic              armed_i,
    input  logic              waiting_i,
    output snp_kind_e         kind_o
);
    logic hit;

    assign hit = valid_i && armed_i && (addr_i == line_i);

    always_comb begin
        kind_o = SNP_NONE;
        if (hit) begin
            kind_o = waiting_i ? SNP_WAKE : SNP_PEND;
        end
    end
endmodule

// File: rtl/line_monitor.sv
module line_monitor
    import lmon_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          arm_req_i,
    input  logic [ADDR_W-1:0]             arm_vaddr_i,
    input  logic                          wait_req_i,
    input  logic [ADDR_W-1:0]             wait_paddr_i,
    input  logic                          snoop_valid_i,
    input  logic [ADDR_W-1:0]             snoop_paddr_i,
    output logic                          armed_o,
    output logic                          waiting_o,
    output logic [ADDR_W-1:0]             mon_vaddr_o,
    output logic [ADDR_W-1:0]             mon_line_o,
    output logic [$clog2(LINE_BYTES):0]   mon_span_o,
    output logic                          rsp_valid_o,
    output logic                          rsp_sleep_o,
    output logic                          wakeup_o
);
    typedef struct packed {
        logic              armed;
        logic              waiting;
        logic              pending;
        logic              wake;
        logic              rsp_valid;
        logic              rsp_sleep;
        logic [ADDR_W-1:0] vaddr;
        logic [ADDR_W-1:0] line;
    } state_t;

    localparam state_t RESET_STATE = '0;

    state_t            s_d, s_q;
    logic [ADDR_W-1:0] wait_line;
    snp_kind_e         snp_kind;

    lmon_line_align #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_align (
        .addr_i (wait_paddr_i),
        .line_o (wait_line)
    );

    lmon_snoop_cmp #(
        .ADDR_W (ADDR_W)
    ) u_cmp (
        .valid_i   (snoop_valid_i),
        .addr_i    (snoop_paddr_i),
        .line_i    (s_q.line),
        .armed_i   (s_q.armed),
        .waiting_i (s_q.waiting),
        .kind_o    (snp_kind)
    );

    lmon_span_calc #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_span (
        .vaddr_i (s_q.vaddr),
        .span_o  (mon_span_o)
    );

    always_comb begin
        s_d           = s_q;
        s_d.wake      = 1'b0;
        s_d.rsp_valid = 1'b0;
        s_d.rsp_sleep = 1'b0;

        if (arm_req_i) begin
            // Arm wins over any snoop or wait in the same cycle.
            s_d.armed   = 1'b1;
            s_d.vaddr   = arm_vaddr_i;
            s_d.line    = '0;
            s_d.pending = 1'b0;
        end else begin
            // Snoop is judged on the registered state.
            if (snp_kind == SNP_WAKE) begin
                s_d.waiting = 1'b0;
                s_d.wake    = 1'b1;
            end else if (snp_kind == SNP_PEND && !wait_req_i) begin
                s_d.pending = 1'b1;
            end

            // Wait updates are applied after the snoop outcome.
            if (wait_req_i) begin
                s_d.rsp_valid = 1'b1;
                if (s_q.pending) begin
                    s_d.pending   = 1'b0;
                    s_d.rsp_sleep = 1'b0;
                end else begin
                    s_d.line      = wait_line;
                    s_d.waiting   = 1'b1;
                    s_d.rsp_sleep = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= RESET_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign armed_o     = s_q.armed;
    assign waiting_o   = s_q.waiting;
    assign mon_vaddr_o = s_q.vaddr;
    assign mon_line_o  = s_q.line;
    assign rsp_valid_o = s_q.rsp_valid;
    assign rsp_sleep_o = s_q.rsp_sleep;
    assign wakeup_o    = s_q.wake;
endmodule

// File: rtl/lmon_checker.sv
module lmon_checker #(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        arm_req_i,
    input logic [ADDR_W-1:0]           arm_vaddr_i,
    input logic                        wait_req_i,
    input logic                        armed_o,
    input logic                        waiting_o,
    input logic [ADDR_W-1:0]           mon_vaddr_o,
    input logic [ADDR_W-1:0]           mon_line_o,
    input logic [$clog2(LINE_BYTES):0] mon_span_o,
    input logic                        rsp_valid_o,
    input logic                        rsp_sleep_o,
    input logic                        wakeup_o
);
    localparam int SPAN_W = $clog2(LINE_BYTES) + 1;
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(LINE_BYTES - 1);

    a_r1_sleep_implies_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_sleep_o |-> rsp_valid_o);

    a_r2_arm_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_req_i |=> armed_o && (mon_line_o == '0) && (mon_vaddr_o == $past(arm_vaddr_i)));

    a_r3_sleep_line_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && rsp_sleep_o) |-> waiting_o && ((mon_line_o & LOW_MASK) == '0));

    a_r4_early_return_keeps_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && !rsp_sleep_o) |-> $stable(mon_line_o));

    a_r5_wake_needs_armed_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wakeup_o |-> $past(armed_o) && $past(waiting_o));

    a_r5_wake_clears_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wakeup_o |-> (!waiting_o || $past(wait_req_i)));

    a_r7_arm_blocks_others: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_req_i |=> !wakeup_o && !rsp_valid_o);

    a_r8_span_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mon_span_o != '0) && (mon_span_o <= SPAN_W'(LINE_BYTES)));
endmodule

bind line_monitor lmon_checker #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
) u_lmon_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_req_i   (arm_req_i),
    .arm_vaddr_i (arm_vaddr_i),
    .wait_req_i  (wait_req_i),
    .armed_o     (armed_o),
    .waiting_o   (waiting_o),
    .mon_vaddr_o (mon_vaddr_o),
    .mon_line_o  (mon_line_o),
    .mon_span_o  (mon_span_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_sleep_o (rsp_sleep_o),
    .wakeup_o    (wakeup_o)
);

// File: tb/line_monitor_tb.sv
module line_monitor_tb_top;
    localparam int AW = 12;
    localparam int LB = 16;
    localparam int OW = $clog2(LB);

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          arm_req_i = 1'b0;
    logic [AW-1:0] arm_vaddr_i = '0;
    logic          wait_req_i = 1'b0;
    logic [AW-1:0] wait_paddr_i = '0;
    logic          snoop_valid_i = 1'b0;
    logic [AW-1:0] snoop_paddr_i = '0;
    logic          armed_o, waiting_o, rsp_valid_o, rsp_sleep_o, wakeup_o;
    logic [AW-1:0] mon_vaddr_o, mon_line_o;
    logic [OW:0]   mon_span_o;

    int errors = 0;
    int checks = 0;

    always #10 clk_i = ~clk_i;

    line_monitor #(.ADDR_W(AW), .LINE_BYTES(LB)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .arm_req_i(arm_req_i), .arm_vaddr_i(arm_vaddr_i),
        .wait_req_i(wait_req_i), .wait_paddr_i(wait_paddr_i),
        .snoop_valid_i(snoop_valid_i), .snoop_paddr_i(snoop_paddr_i),
        .armed_o(armed_o), .waiting_o(waiting_o),
        .mon_vaddr_o(mon_vaddr_o), .mon_line_o(mon_line_o), .mon_span_o(mon_span_o),
        .rsp_valid_o(rsp_valid_o), .rsp_sleep_o(rsp_sleep_o), .wakeup_o(wakeup_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Inputs are driven after a falling edge and results read at the next falling edge.
    task automatic cycle();
        @(negedge clk_i);
        arm_req_i = 1'b0;
        wait_req_i = 1'b0;
        snoop_valid_i = 1'b0;
    endtask

    task automatic do_arm(input logic [AW-1:0] a);
        arm_req_i = 1'b1; arm_vaddr_i = a; cycle();
    endtask

    task automatic do_wait(input logic [AW-1:0] p);
        wait_req_i = 1'b1; wait_paddr_i = p; cycle();
    endtask

    task automatic do_snoop(input logic [AW-1:0] s);
        snoop_valid_i = 1'b1; snoop_paddr_i = s; cycle();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R1 reset state
        chk("R1", "armed", armed_o, 0);
        chk("R1", "waiting", waiting_o, 0);
        chk("R1", "wakeup", wakeup_o, 0);
        chk("R1", "rsp_valid", rsp_valid_o, 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R1", "armed after release", armed_o, 0);
        // R1: no pending after reset, so a wait sleeps
        do_wait(12'h040);
        chk("R1", "wait sleeps after reset", rsp_sleep_o, 1);

        // R8 / R2 span sweep over two lines
        for (int a = 0; a < 2 * LB; a++) begin
            do_arm(AW'(12'h200 + a));
            chk("R2", "vaddr stored", mon_vaddr_o, 12'h200 + a);
            chk("R2", "line zeroed", mon_line_o, 0);
            chk("R2", "armed", armed_o, 1);
            chk("R8", "span", mon_span_o, LB - ((12'h200 + a) % LB));
        end

        // R3 line masking sweep
        for (int p = 0; p < 256; p++) begin
            do_wait(AW'(12'h300 + p));
            chk("R3", "aligned line", mon_line_o, (12'h300 + p) & ~(LB - 1));
            chk("R3", "sleep", rsp_sleep_o, 1);
            chk("R3", "rsp valid", rsp_valid_o, 1);
            chk("R3", "waiting", waiting_o, 1);
        end

        // R5 snoop sweep against line 0x130
        for (int k = 0; k < 64; k++) begin
            logic [AW-1:0] s;
            bit hit;
            s = AW'(12'h100 + k * 2);
            hit = (s == 12'h130);
            do_arm(12'h500);
            do_wait(12'h13A);
            do_snoop(s);
            chk("R5", "wakeup", wakeup_o, int'(hit));
            chk("R5", "waiting", waiting_o, int'(!hit));
            @(negedge clk_i);
            chk("R5", "pulse ends", wakeup_o, 0);
        end

        // R5 snoop ignored when not armed: fresh reset, then waiting but unarmed
        rst_ni = 1'b0; @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);
        do_wait(12'h070);
        do_snoop(12'h070);
        chk("R5", "unarmed no wake", wakeup_o, 0);
        chk("R5", "unarmed keeps waiting", waiting_o, 1);

        // R6 / R4 pending wakeup path: snoop before wait
        do_arm(12'h123);
        do_snoop(12'h001);
        chk("R5", "mismatch no wake", wakeup_o, 0);
        do_wait(12'h7F0);
        chk("R5", "mismatch left no pending", rsp_sleep_o, 1);
        do_snoop(12'h7F0);
        chk("R5", "wakeup", wakeup_o, 1);
        chk("R5", "waiting cleared", waiting_o, 0);
        do_snoop(12'h7F0);
        chk("R6", "no wake when not waiting", wakeup_o, 0);
        do_wait(12'h450);
        chk("R4", "no sleep", rsp_sleep_o, 0);
        chk("R4", "rsp valid", rsp_valid_o, 1);
        chk("R4", "waiting unchanged", waiting_o, 0);
        chk("R4", "line unchanged", mon_line_o, 12'h7F0);
        do_wait(12'h450);
        chk("R4", "pending consumed", rsp_sleep_o, 1);
        chk("R4", "line now stored", mon_line_o, 12'h450);

        // R7 arm with snoop: snoop ignored, waiting kept
        arm_req_i = 1'b1; arm_vaddr_i = 12'h0A0;
        snoop_valid_i = 1'b1; snoop_paddr_i = 12'h450;
        cycle();
        chk("R7", "no wake", wakeup_o, 0);
        chk("R7", "waiting kept", waiting_o, 1);
        chk("R7", "line zeroed", mon_line_o, 0);
        // R7 arm clears pending
        do_arm(12'h0A0);
        do_snoop(12'h000);
        chk("R7", "hit on zero line wakes", wakeup_o, 1);
        do_snoop(12'h000);
        do_arm(12'h0B0);
        do_wait(12'h222);
        chk("R7", "pending cleared by arm", rsp_sleep_o, 1);
        // R7 arm with wait: wait dropped
        arm_req_i = 1'b1; arm_vaddr_i = 12'h0C0;
        wait_req_i = 1'b1; wait_paddr_i = 12'h333;
        cycle();
        chk("R7", "no response", rsp_valid_o, 0);
        chk("R7", "line zero", mon_line_o, 0);

        // R9 wait and snoop same cycle
        do_wait(12'h660);
        wait_req_i = 1'b1; wait_paddr_i = 12'h680;
        snoop_valid_i = 1'b1; snoop_paddr_i = 12'h660;
        cycle();
        chk("R9", "wakeup", wakeup_o, 1);
        chk("R9", "waiting from wait", waiting_o, 1);
        chk("R9", "sleep", rsp_sleep_o, 1);
        chk("R9", "new line", mon_line_o, 12'h680);
        // R9 pending not set when wait collides with pending-type snoop
        do_snoop(12'h680);
        wait_req_i = 1'b1; wait_paddr_i = 12'h690;
        snoop_valid_i = 1'b1; snoop_paddr_i = 12'h680;
        cycle();
        chk("R9", "sleeps", rsp_sleep_o, 1);
        do_wait(12'h6A0);
        chk("R9", "no pending left", rsp_sleep_o, 1);

        summary();
        $finish;
    end
endmodule